// File: doc/BRIEF.md
# Control Endpoint Handshake Controller

This block is the device-side hardware behind control endpoint zero. It has a 16-byte receive buffer that collects SETUP and OUT packet payloads, and a 16-byte transmit buffer that holds the next IN payload. Firmware reads and writes both buffers, and the endpoint flags, through a small byte-wide register port. A level-sensitive interrupt line tells firmware when a packet has landed or when the host has acknowledged transmitted data.

The packet side is abstract. The block is told when a packet starts and whether it is a SETUP, then gets its payload bytes one per strobe, then gets an end strobe. It answers every OUT or SETUP packet with an ACK or NAK pulse. It answers every IN token with a NAK, a zero-length packet or a streamed payload, and it takes a host ACK strobe. A payload stays in the transmit buffer until the host ACKs it, so a lost handshake is retried with the same data and firmware does nothing. Serial coding, CRC and request parsing live elsewhere.

Top module: `ep0_ctrl`

## Requirements
- R1: When a SETUP packet ends, the setup-active flag (status bit 2) and the OUT-ready flag (status bit 0) are set, the endpoint source bit (source register address 2, bit 0) is set, and `hs_ack` pulses in the cycle after `rx_end`. A SETUP start flushes the receive buffer first.
- R2: Status bit 3 (receive-not-empty) is 1 while unread bytes remain. Each read of the data register (address 1) returns the oldest byte and removes it.
- R3: An IN token that arrives while the IN-ready flag (status bit 1) is clear gets an `in_nak` pulse in the next cycle, and no data is sent.
- R4: With IN-ready set, the next IN token streams the buffered bytes in write order, starting the cycle after the token, and `tx_last` marks the final byte. A repeated token with no host ACK sends the same bytes again. A host ACK clears IN-ready, empties the transmit buffer and sets the source bit.
- R5: An IN token with IN-ready set and an empty transmit buffer gives a `tx_zlp` pulse and no data. A full 16-byte payload is sent whole.
- R6: `irq` follows the summary bit (address 4, bit 0). The summary bit is set while an enabled source bit is set, and a write of 1 does not clear it while the source bit is still set. Clearing the source and then the summary drops `irq`.
- R7: After reset all flags, source, summary and `irq` are 0, and the enable register (address 3) reads 0x01. With enable bit 0 cleared, a source event does not raise `irq`.
- R8: Data-register writes beyond 16 bytes are dropped and set a sticky overflow bit (status bit 4). Writing 1 to that bit clears it.
- R9: Writing 1 to status bits 0 and 2 clears them. Writing 1 to bit 1 sets IN-ready, and a write of 0 leaves it unchanged.
- R10: An OUT packet that starts while OUT-ready is set is NAKed with `hs_nak`, and its bytes are discarded. An OUT packet accepted with OUT-ready clear is ACKed.
- R11: A SETUP start clears IN-ready and empties the transmit buffer, so a following IN token is NAKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Strobe: a SETUP or OUT packet begins |
| rx_setup | input | 1 | Qualifies `rx_start`: 1 for SETUP |
| rx_valid | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| rx_end | input | 1 | Strobe: packet complete |
| hs_ack | output | 1 | ACK answer to the packet that just ended |
| hs_nak | output | 1 | NAK answer to the packet that just ended |
| in_token | input | 1 | Strobe: IN token for this endpoint |
| host_ack | input | 1 | Strobe: host acknowledged the IN data |
| in_nak | output | 1 | NAK answer to the IN token |
| tx_zlp | output | 1 | Zero-length packet answer |
| tx_valid | output | 1 | IN payload byte valid |
| tx_data | output | 8 | IN payload byte |
| tx_last | output | 1 | Final payload byte |
| reg_addr | input | 3 | Register address: 0 status, 1 data, 2 source, 3 enable, 4 summary |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the data register) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the same cycle as the address |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is an IN transfer that the host never acknowledged. Here the payload has been streamed but must still be whole for a resend, and a SETUP can cut in before the ACK arrives. The bench reaches it by issuing an IN token, collecting the stream, and issuing a second token with no `host_ack`, then comparing the two streams. A separate scenario arms a payload and then injects a SETUP to show that the resend buffer and IN-ready are gone. Overflow and the 16-byte boundary are reached by writing 18 bytes, then checking that exactly the first 16 leave the block.

// File: rtl/ep0_ctrl.sv
module ep0_ctrl #(
  parameter int MAXP = 16,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_start,
  input  logic          rx_setup,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_end,
  output logic          hs_ack,
  output logic          hs_nak,
  input  logic          in_token,
  input  logic          host_ack,
  output logic          in_nak,
  output logic          tx_zlp,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int AW = $clog2(MAXP);
  localparam int CW = $clog2(MAXP + 1);

  logic [DW-1:0] rx_mem [MAXP];
  logic [DW-1:0] tx_mem [MAXP];
  logic [AW-1:0] rx_rd, tx_idx;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic rx_take, rx_is_setup, sending;
  logic opr, sa, ipr, ovf, src, sum;
  logic [DW-1:0] en;

  wire setup_start = rx_start && rx_setup;
  wire csr_wr  = reg_wr && reg_addr == 3'd0;
  wire dat_wr  = reg_wr && reg_addr == 3'd1;
  wire pop     = reg_rd && reg_addr == 3'd1 && rx_cnt != '0;
  wire push    = rx_valid && rx_take && rx_cnt != CW'(MAXP);
  wire rx_done = rx_end && rx_take;
  wire tx_done = host_ack && ipr && !setup_start;
  wire [AW-1:0] rx_wr = rx_rd + rx_cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rd <= '0; rx_cnt <= '0; rx_take <= 1'b0; rx_is_setup <= 1'b0;
      hs_ack <= 1'b0; hs_nak <= 1'b0; opr <= 1'b0; sa <= 1'b0;
    end else begin
      hs_ack <= rx_done;
      hs_nak <= rx_end && !rx_take;
      if (setup_start) begin
        rx_take <= 1'b1; rx_is_setup <= 1'b1; rx_rd <= '0; rx_cnt <= '0;
      end else begin
        if (rx_start) begin
          rx_take <= !opr; rx_is_setup <= 1'b0;
        end else if (rx_end) rx_take <= 1'b0;
        if (push) rx_mem[rx_wr] <= rx_byte;
        rx_cnt <= rx_cnt + CW'(push) - CW'(pop);
        rx_rd  <= rx_rd + AW'(pop);
      end
      if (rx_done) opr <= 1'b1;
      else if (csr_wr && reg_wdata[0]) opr <= 1'b0;
      if (rx_done && rx_is_setup) sa <= 1'b1;
      else if (csr_wr && reg_wdata[2]) sa <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt <= '0; tx_idx <= '0; sending <= 1'b0; ipr <= 1'b0; ovf <= 1'b0;
      in_nak <= 1'b0; tx_zlp <= 1'b0;
    end else begin
      in_nak <= in_token && !ipr;
      tx_zlp <= 1'b0;
      if (csr_wr && reg_wdata[4]) ovf <= 1'b0;
      if (setup_start) begin
        tx_cnt <= '0; ipr <= 1'b0; sending <= 1'b0; tx_idx <= '0;
      end else begin
        if (tx_done) begin
          ipr <= 1'b0; tx_cnt <= '0;
        end else begin
          if (csr_wr && reg_wdata[1]) ipr <= 1'b1;
          if (dat_wr) begin
            if (tx_cnt == CW'(MAXP)) ovf <= 1'b1;
            else begin
              tx_mem[tx_cnt[AW-1:0]] <= reg_wdata;
              tx_cnt <= tx_cnt + 1'b1;
            end
          end
        end
        if (sending) begin
          tx_idx <= tx_idx + 1'b1;
          if (tx_last) sending <= 1'b0;
        end else if (in_token && ipr) begin
          if (tx_cnt == '0) tx_zlp <= 1'b1;
          else begin
            sending <= 1'b1; tx_idx <= '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src <= 1'b0; sum <= 1'b0; en <= DW'(1);
    end else begin
      if (rx_done || tx_done) src <= 1'b1;
      else if (reg_wr && reg_addr == 3'd2 && reg_wdata[0]) src <= 1'b0;
      if (reg_wr && reg_addr == 3'd3) en <= reg_wdata;
      if (src && en[0]) sum <= 1'b1;
      else if (reg_wr && reg_addr == 3'd4 && reg_wdata[0]) sum <= 1'b0;
    end
  end

  assign tx_valid = sending;
  assign tx_data  = tx_mem[tx_idx];
  assign tx_last  = sending && (CW'(tx_idx) + CW'(1)) == tx_cnt;
  assign irq      = sum;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata[4:0] = {ovf, rx_cnt != '0, sa, ipr, opr};
      3'd1: reg_rdata = (rx_cnt != '0) ? rx_mem[rx_rd] : '0;
      3'd2: reg_rdata[0] = src;
      3'd3: reg_rdata = en;
      3'd4: reg_rdata[0] = sum;
      default: reg_rdata = '0;
    endcase
  end
endmodule

module ep0_ctrl_chk #(
  parameter int MAXP = 16,
  parameter int CW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_token,
  input logic          host_ack,
  input logic          ipr,
  input logic          in_nak,
  input logic          tx_zlp,
  input logic [CW-1:0] tx_cnt,
  input logic          sending,
  input logic          sa,
  input logic          opr,
  input logic          src,
  input logic          en0,
  input logic          irq,
  input logic          reg_wr,
  input logic          setup_start
);
  AST_SETUP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) $rose(sa) |-> opr && src); // R1
  AST_NAK_UNARMED: assert property (@(posedge clk) disable iff (!rst_n) in_token && !ipr |=> in_nak); // R3
  AST_IPR_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack && ipr && !setup_start && !reg_wr |=> !ipr && src); // R4
  AST_ZLP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    in_token && ipr && !sending && tx_cnt == '0 && !setup_start |=> tx_zlp); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) irq && src && en0 |=> irq); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(MAXP)); // R8
endmodule

bind ep0_ctrl ep0_ctrl_chk #(.MAXP(MAXP), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_token(in_token), .host_ack(host_ack), .ipr(ipr),
  .in_nak(in_nak), .tx_zlp(tx_zlp), .tx_cnt(tx_cnt), .sending(sending), .sa(sa),
  .opr(opr), .src(src), .en0(en[0]), .irq(irq), .reg_wr(reg_wr), .setup_start(setup_start)
);

// File: tb/sim_ep0_ctrl.sv
module sim_ep0_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_start = 0, rx_setup = 0, rx_valid = 0, rx_end = 0;
  logic [7:0] rx_byte = 0;
  logic hs_ack, hs_nak, in_nak, tx_zlp, tx_valid, tx_last, irq;
  logic in_token = 0, host_ack = 0;
  logic [7:0] tx_data, reg_rdata;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] got [32];
  int gotn;
  bit last_ok, saw_nak, saw_zlp, pk_ack, pk_nak;
  logic [7:0] v;

  always #5 clk = ~clk;

  ep0_ctrl u0 (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); reg_addr = 3'd1; #1 d = reg_rdata; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic send_pkt(input bit s, input int n, input logic [7:0] base);
    @(negedge clk); rx_start = 1; rx_setup = s;
    @(negedge clk); rx_start = 0; rx_setup = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_byte = base + 8'(i); @(negedge clk);
    end
    rx_valid = 0; rx_end = 1;
    @(negedge clk); rx_end = 0; #1 pk_ack = hs_ack; pk_nak = hs_nak;
  endtask

  task automatic in_tok();
    @(negedge clk); in_token = 1;
    @(negedge clk); in_token = 0; #1;
    saw_nak = in_nak; saw_zlp = tx_zlp; gotn = 0; last_ok = 1;
    while (tx_valid && gotn < 32) begin
      got[gotn] = tx_data;
      gotn++;
      @(negedge clk); #1;
      if (tx_last != 0 && !tx_valid) last_ok = 0;
    end
  endtask

  task automatic in_tok_last(input int n);
    @(negedge clk); in_token = 1;
    @(negedge clk); in_token = 0; #1;
    saw_nak = in_nak; saw_zlp = tx_zlp; gotn = 0; last_ok = 1;
    while (tx_valid && gotn < 32) begin
      got[gotn] = tx_data;
      if (tx_last != (gotn == n - 1)) last_ok = 0;
      gotn++;
      @(negedge clk); #1;
    end
  endtask

  task automatic hack();
    @(negedge clk); host_ack = 1;
    @(negedge clk); host_ack = 0;
  endtask

  task automatic clear_irq();
    wr(3'd2, 8'h01); wr(3'd4, 8'h01);
  endtask

  task automatic t_reset();
    rd(3'd0, v); check("R7 status after reset", v, 0);
    rd(3'd3, v); check("R7 enable after reset", v, 8'h01);
    rd(3'd2, v); check("R7 source after reset", v, 0);
    check("R7 irq after reset", irq, 0);
  endtask

  task automatic t_setup();
    send_pkt(1, 8, 8'h80);
    check("R1 hs_ack on setup", pk_ack, 1);
    rd(3'd0, v); check("R1 status SA|OPR|RNE", v, 8'h0D);
    rd(3'd2, v); check("R1 source set", v, 1);
    check("R1 irq raised", irq, 1);
    for (int i = 0; i < 8; i++) begin
      pop(v); check("R2 drained byte", v, 8'h80 + i);
    end
    rd(3'd0, v); check("R2 RNE cleared when empty", v, 8'h05);
  endtask

  task automatic t_irq_level();
    wr(3'd4, 8'h01); check("R6 summary clear ignored while source set", irq, 1);
    wr(3'd2, 8'h01); check("R6 irq held after source clear", irq, 1);
    wr(3'd4, 8'h01); check("R6 irq drops after both clears", irq, 0);
    wr(3'd0, 8'h05); rd(3'd0, v); check("R9 SA and OPR write-1-clear", v, 0);
  endtask

  task automatic t_out_nak();
    send_pkt(0, 2, 8'hA1);
    check("R10 OUT accepted ack", pk_ack, 1);
    rd(3'd0, v); check("R10 OPR|RNE after OUT", v, 8'h09);
    send_pkt(0, 1, 8'hB1);
    check("R10 OUT nak while OPR set", pk_nak, 1);
    check("R10 no ack while OPR set", pk_ack, 0);
    pop(v); check("R10 first byte kept", v, 8'hA1);
    pop(v); check("R10 second byte kept", v, 8'hA2);
    rd(3'd0, v); check("R10 dropped packet not buffered", v, 8'h01);
    wr(3'd0, 8'h01); clear_irq();
  endtask

  task automatic t_in_nak();
    in_tok();
    check("R3 nak when unarmed", saw_nak, 1);
    check("R3 no data when unarmed", gotn, 0);
  endtask

  task automatic t_in_data();
    for (int i = 0; i < 5; i++) wr(3'd1, 8'h30 + 8'(i));
    wr(3'd0, 8'h02);
    wr(3'd0, 8'h00);
    rd(3'd0, v); check("R9 IPR set, write 0 no effect", v, 8'h02);
    in_tok_last(5);
    check("R4 byte count", gotn, 5);
    for (int i = 0; i < 5; i++) check("R4 byte order", got[i], 8'h30 + i);
    check("R4 last marker", last_ok, 1);
    in_tok_last(5);
    check("R4 resend count", gotn, 5);
    check("R4 resend first", got[0], 8'h30);
    check("R4 resend final", got[4], 8'h34);
    hack();
    rd(3'd0, v); check("R4 IPR cleared by host ack", v, 0);
    rd(3'd2, v); check("R4 source set on ack", v, 1);
    in_tok(); check("R4 nak after ack", saw_nak, 1);
    clear_irq();
  endtask

  task automatic t_zlp();
    wr(3'd0, 8'h02);
    in_tok();
    check("R5 zlp on empty arm", saw_zlp, 1);
    check("R5 zlp carries no data", gotn, 0);
    hack(); clear_irq();
  endtask

  task automatic t_full_ovf();
    for (int i = 0; i < 18; i++) wr(3'd1, 8'(i));
    rd(3'd0, v); check("R8 overflow bit set", v, 8'h10);
    wr(3'd0, 8'h02);
    in_tok_last(16);
    check("R5 full packet 16 bytes", gotn, 16);
    check("R8 extra bytes dropped", got[15], 15);
    check("R5 last marker on byte 16", last_ok, 1);
    wr(3'd0, 8'h10); rd(3'd0, v); check("R8 overflow cleared", v, 8'h02);
    hack(); clear_irq();
  endtask

  task automatic t_setup_abort();
    for (int i = 0; i < 3; i++) wr(3'd1, 8'h55);
    wr(3'd0, 8'h02);
    send_pkt(1, 8, 8'h00);
    rd(3'd0, v); check("R11 IPR cleared by setup", v[1], 0);
    in_tok(); check("R11 nak after setup abort", saw_nak, 1);
    for (int i = 0; i < 8; i++) pop(v);
    wr(3'd0, 8'h05); clear_irq();
    wr(3'd0, 8'h02);
    in_tok(); check("R11 tx buffer flushed", saw_zlp, 1);
    hack(); clear_irq();
  endtask

  task automatic t_en_disabled();
    wr(3'd3, 8'h00);
    send_pkt(0, 1, 8'h11);
    rd(3'd2, v); check("R7 source set while disabled", v, 1);
    check("R7 irq masked by enable", irq, 0);
    pop(v); wr(3'd0, 8'h01); wr(3'd2, 8'h01); wr(3'd3, 8'h01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_setup();
    t_irq_level();
    t_out_nak();
    t_in_nak();
    t_in_data();
    t_zlp();
    t_full_ovf();
    t_setup_abort();
    t_en_disabled();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule